// File: doc/BRIEF.md
# Four-Word Burst Double-Rate Static Memory

This block is a synthesizable model of a static memory that moves data in bursts of four 36-bit words. It abstracts the double-rate data bus as two 36-bit words per rising clock edge, so each edge carries a 72-bit word pair. A command is given by pulling the load strobe low together with a read/write select and an address. The low two address bits pick the first word of the burst, and the remaining bits pick a 144-bit line in an internal array. A write supplies its four words over the two edges after the command, each word with four active-low byte enables. A read returns its four words over the two edges after the command.

Writes are posted. A completed write stays in a single holding line until the next write command arrives, and only then is it merged into the array. A read served while a posted write is held sees that write's bytes wherever the held line has them, and sees array contents elsewhere. A command offered on the edge right after an accepted one is dropped without effect, so commands are taken on every other edge at most. Outside a read burst the data bus is driven to zero and the output-enable is low, which models the high-impedance state.

Top module: `burst_ddr_sram`

## Requirements
- R1: A command is accepted on a rising edge where `ldN` is 0 and the edge before it accepted no command. `rwN` = 1 selects a read, `rwN` = 0 a write.
- R2: Burst word k (k = 0..3) addresses line `addr[ADDR_W-1:2]`, word index (`addr[1:0]` + k) mod 4. A start of 2 therefore gives the order 2, 3, 0, 1.
- R3: A command offered on the edge right after an accepted command is ignored. It produces no read data and changes no stored byte.
- R4: A write accepted at edge t takes words 0 and 1 at edge t+1 and words 2 and 3 at edge t+2. In each pair, `dataIn[35:0]` carries the earlier word and `dataIn[71:36]` the later one. `bwN[3:0]` qualifies the earlier word and `bwN[7:4]` the later one.
- R5: Within a word, enable bit b (active low) covers bits 9b+8 down to 9b. A byte whose enable is 1 keeps its stored value. `dataIn` and `bwN` have no effect on edges that carry no write data.
- R6: A read accepted at edge t drives words 0 and 1 after edge t+1 and words 2 and 3 after edge t+2, with `dataOut[35:0]` the earlier word. `dataValid` and `outEnable` are 1 in exactly those two cycles.
- R7: A completed write is held until the next accepted write, which commits it to the array. Once committed, its bytes stay readable after the holding line has been reloaded.
- R8: A read of the held line returns, byte by byte, the held data where the pending write enabled that byte. Everywhere else it returns the array contents.
- R9: After reset, `dataValid` and `outEnable` are 0 and `dataOut` is 0. Whenever `outEnable` is 0, `dataOut` is 0.
- R10: `outEnable` falls on the first edge that delivers no read word. That is one cycle after the last read pair, when no further read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| ldN | input | 1 | Command strobe, active low |
| rwN | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Line address in bits above 1, burst start in bits 1:0 |
| dataIn | input | 72 | Write word pair, earlier word in bits 35:0 |
| bwN | input | 8 | Active-low byte enables, bits 3:0 for the earlier word |
| dataOut | output | 72 | Read word pair, earlier word in bits 35:0 |
| dataValid | output | 1 | Read pair present on `dataOut` |
| outEnable | output | 1 | Data bus driven (low models high impedance) |

## Verification
The bench builds the block with `BURST_LOCS` = 8, so the address is 5 bits wide and a reference array of eight lines fits in the bench. At that size a sweep covers every line, every burst start and all sixteen byte-enable patterns. Reads follow writes in the very next command slot, which drives the byte-wise forwarding path. Extra back-to-back writes force commits while earlier data is still held. Stray commands offered on the dropped edge, and stray enables on idle edges, can be seen at the ports through later reads.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int WORD_W = 36;
  localparam int BYTE_W = 9;
  localparam int BYTES  = WORD_W / BYTE_W;
  localparam int WORDS  = 4;
  localparam int PAIR   = 2;

  typedef logic [WORDS-1:0][BYTES-1:0][BYTE_W-1:0] line_t;
  typedef logic [WORDS-1:0][BYTES-1:0]             lineMask_t;
  typedef logic [PAIR-1:0][BYTES-1:0][BYTE_W-1:0]  pair_t;
  typedef logic [PAIR-1:0][BYTES-1:0]              pairMask_t;

  typedef struct packed {
    logic       wrCmd;   // write accepted on this edge
    logic       wrBeat;  // write word pair present on this edge
    logic       rdBeat;  // read word pair due on this edge
    logic       beatHi;  // second pair of the burst
    logic [1:0] startLo; // burst start word
  } strobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int UP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ldN,
  input  logic            rwN,
  input  logic [UP_W+1:0] addr,
  output strobe_t         st,
  output logic [UP_W-1:0] curUp,
  output logic [UP_W-1:0] cmdUp,
  output logic            cmdAccept
);
  logic       beat1, beat2, curRead;
  logic [1:0] curLo;

  // only every other edge can take a command
  assign cmdAccept = !ldN && !beat1;
  assign cmdUp     = addr[UP_W+1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beat1   <= 1'b0;
      beat2   <= 1'b0;
      curRead <= 1'b0;
      curLo   <= '0;
      curUp   <= '0;
    end else begin
      beat1 <= cmdAccept;
      beat2 <= beat1;
      if (cmdAccept) begin
        curRead <= rwN;
        curLo   <= addr[1:0];
        curUp   <= addr[UP_W+1:2];
      end
    end
  end

  always_comb begin
    st.wrCmd   = cmdAccept && !rwN;
    st.wrBeat  = (beat1 || beat2) && !curRead;
    st.rdBeat  = (beat1 || beat2) && curRead;
    st.beatHi  = beat2;
    st.startLo = curLo;
  end
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int UP_W = 8,
  localparam int DEPTH = 1 << UP_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                st,
  input  logic [UP_W-1:0]        curUp,
  input  logic [UP_W-1:0]        cmdUp,
  input  logic [PAIR*WORD_W-1:0] dataIn,
  input  logic [PAIR*BYTES-1:0]  bwN,
  output logic [PAIR*WORD_W-1:0] dataOut,
  output logic                   dataValid,
  output logic                   outEnable
);
  line_t           mem [DEPTH];
  line_t           pendData, pendDataNext;
  lineMask_t       pendMask, pendMaskNext;
  logic [UP_W-1:0] pendUp;
  logic            pendValid;
  pair_t           inPair, rdPair;
  pairMask_t       inMaskN;
  logic [1:0]      wIdx [PAIR];

  assign inPair  = dataIn;
  assign inMaskN = bwN;
  assign wIdx[0] = st.startLo + {st.beatHi, 1'b0};
  assign wIdx[1] = wIdx[0] + 2'd1;

  // holding line with the current write pair folded in
  always_comb begin
    pendDataNext = pendData;
    pendMaskNext = pendMask;
    if (st.wrBeat) begin
      for (int p = 0; p < PAIR; p++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (!inMaskN[p][b]) begin
            pendDataNext[wIdx[p]][b] = inPair[p][b];
            pendMaskNext[wIdx[p]][b] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendData  <= '0;
      pendMask  <= '0;
      pendUp    <= '0;
      pendValid <= 1'b0;
    end else if (st.wrCmd) begin
      pendData  <= '0;
      pendMask  <= '0;
      pendUp    <= cmdUp;
      pendValid <= 1'b1;
    end else begin
      pendData <= pendDataNext;
      pendMask <= pendMaskNext;
    end
  end

  // commit of the posted write when the next write arrives
  always_ff @(posedge clk) begin
    if (st.wrCmd && pendValid) begin
      for (int w = 0; w < WORDS; w++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (pendMaskNext[w][b]) mem[pendUp][w][b] <= pendDataNext[w][b];
        end
      end
    end
  end

  // per-byte forwarding from the holding line
  always_comb begin
    for (int p = 0; p < PAIR; p++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (pendValid && pendUp == curUp && pendMask[wIdx[p]][b])
          rdPair[p][b] = pendData[wIdx[p]][b];
        else
          rdPair[p][b] = mem[curUp][wIdx[p]][b];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
      outEnable <= 1'b0;
    end else begin
      dataOut   <= st.rdBeat ? rdPair : '0;
      dataValid <= st.rdBeat;
      outEnable <= st.rdBeat;
    end
  end
endmodule

// File: rtl/burst_ddr_sram.sv
module burst_ddr_sram
  import burst_sram_pkg::*;
#(
  parameter int BURST_LOCS = 256,
  localparam int UP_W   = $clog2(BURST_LOCS),
  localparam int ADDR_W = UP_W + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ldN,
  input  logic                   rwN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [PAIR*WORD_W-1:0] dataIn,
  input  logic [PAIR*BYTES-1:0]  bwN,
  output logic [PAIR*WORD_W-1:0] dataOut,
  output logic                   dataValid,
  output logic                   outEnable
);
  strobe_t         st;
  logic [UP_W-1:0] curUp, cmdUp;
  logic            cmdAccept;

  burst_sram_ctrl #(.UP_W(UP_W)) ctrl (
    .clk(clk), .rstN(rstN), .ldN(ldN), .rwN(rwN), .addr(addr),
    .st(st), .curUp(curUp), .cmdUp(cmdUp), .cmdAccept(cmdAccept)
  );

  burst_sram_dp #(.UP_W(UP_W)) dp (
    .clk(clk), .rstN(rstN), .st(st), .curUp(curUp), .cmdUp(cmdUp),
    .dataIn(dataIn), .bwN(bwN),
    .dataOut(dataOut), .dataValid(dataValid), .outEnable(outEnable)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int DW = 72
) (
  input logic          clk,
  input logic          rstN,
  input logic          ldN,
  input logic          rwN,
  input logic          cmdAccept,
  input logic          dataValid,
  input logic          outEnable,
  input logic [DW-1:0] dataOut
);
  AST_ACCEPT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccept |-> !ldN);                                        // R1
  AST_ACCEPT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccept |=> !cmdAccept);                                  // R3
  AST_READ_TWO_BEATS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |=> dataValid);                            // R6
  AST_READ_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(cmdAccept && rwN, 2));           // R6
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> dataOut == '0);                              // R9
  AST_ENABLE_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outEnable) |-> !dataValid);                           // R10
endmodule

bind burst_ddr_sram burst_sram_chk #(.DW(72)) chk (
  .clk(clk), .rstN(rstN), .ldN(ldN), .rwN(rwN), .cmdAccept(cmdAccept),
  .dataValid(dataValid), .outEnable(outEnable), .dataOut(dataOut)
);

// File: tb/burst_ddr_sram_test.sv
module burst_ddr_sram_test;
  localparam int LOCS = 8;
  localparam int AW   = 5;

  logic        clk = 1'b0;
  logic        rstN, ldN, rwN;
  logic [AW-1:0] addr;
  logic [71:0] dataIn, dataOut;
  logic [7:0]  bwN;
  logic        dataValid, outEnable;

  always #4 clk = ~clk;

  burst_ddr_sram #(.BURST_LOCS(LOCS)) uut (
    .clk(clk), .rstN(rstN), .ldN(ldN), .rwN(rwN), .addr(addr),
    .dataIn(dataIn), .bwN(bwN), .dataOut(dataOut),
    .dataValid(dataValid), .outEnable(outEnable)
  );

  int vecs = 0, errs = 0;
  logic [35:0] refMem [LOCS][4];
  logic [3:0][35:0] prevExp, prevW;
  logic [3:0][3:0]  prevM;
  int    prevKind = 0;
  string prevTag  = "R10 idle";

  task automatic check(string tag, logic [73:0] act, logic [73:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  function automatic logic [35:0] mkw(int s);
    logic [31:0] h;
    h = 32'(s) * 32'h9E3779B1;
    return {h[7:4], h ^ 32'(s << 9)};
  endfunction

  // kind: 0 no-op, 1 write, 2 read; one command slot is two clock cycles
  task automatic slot(int kind, logic [AW-1:0] a, logic [3:0][35:0] w,
                      logic [3:0][3:0] m, bit poke, string tag);
    logic [73:0] e;
    @(negedge clk);
    // R6: first pair of the previous read, or idle bus (R9/R10)
    e = (prevKind == 2) ? {2'b11, prevExp[1], prevExp[0]} : '0;
    check(prevTag, {dataValid, outEnable, dataOut}, e);
    ldN  = (kind == 0);
    rwN  = (kind == 2);
    addr = a;
    if (prevKind == 1) begin
      dataIn = {prevW[3], prevW[2]}; bwN = {prevM[3], prevM[2]};  // R4
    end else begin
      dataIn = {mkw(vecs), mkw(vecs + 7)}; bwN = 8'h00;          // R5 stray
    end
    @(negedge clk);
    e = (prevKind == 2) ? {2'b11, prevExp[3], prevExp[2]} : '0;
    check(prevTag, {dataValid, outEnable, dataOut}, e);
    // R3: a command offered on the dropped edge
    ldN  = !(poke && kind != 0);
    rwN  = vecs[1];
    addr = ~a;
    if (kind == 1) begin
      dataIn = {w[1], w[0]}; bwN = {m[1], m[0]};
    end else begin
      dataIn = {mkw(vecs + 3), mkw(vecs + 5)}; bwN = 8'h00;
    end
    if (kind == 1) begin
      for (int k = 0; k < 4; k++) begin
        int idx = (int'(a[1:0]) + k) % 4;
        for (int b = 0; b < 4; b++)
          if (!m[k][b]) refMem[a[AW-1:2]][idx][b*9 +: 9] = w[k][b*9 +: 9];
      end
    end
    if (kind == 2)
      for (int k = 0; k < 4; k++) prevExp[k] = refMem[a[AW-1:2]][(int'(a[1:0]) + k) % 4];
    prevKind = kind;
    prevW    = w;
    prevM    = m;
    prevTag  = (kind == 2) ? tag : "R10 idle bus";
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL R1 watchdog: run incomplete, expected end of sweep");
    summary();
  end

  initial begin
    logic [3:0][35:0] w;
    logic [3:0][3:0]  m;
    int i;
    rstN = 1'b0; ldN = 1'b1; rwN = 1'b1; addr = '0; dataIn = '0; bwN = 8'hFF;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset", {dataValid, outEnable, dataOut}, '0);
    rstN = 1'b1;
    // fill every line, full enables, assorted starts (R2 wrap)
    for (int l = 0; l < LOCS; l++) begin
      for (int k = 0; k < 4; k++) w[k] = mkw(l * 4 + k + 1000);
      slot(1, AW'({3'(l), 2'(l)}), w, '0, 1'b0, "");
    end
    i = 0;
    for (int loc = 0; loc < LOCS; loc++)
      for (int lo = 0; lo < 4; lo++)
        for (int mp = 0; mp < 16; mp++) begin
          for (int k = 0; k < 4; k++) begin
            w[k] = mkw(i * 4 + k);
            m[k] = 4'((mp + k * 5) & 15);
          end
          // R1 R4 R5: masked write with chosen start
          slot(1, AW'({3'(loc), 2'(lo)}), w, m, (i % 3) == 0, "");
          if (i % 4 == 2) begin
            for (int k = 0; k < 4; k++) w[k] = mkw(i * 4 + k + 5000);
            // R7: back-to-back write commits the previous one
            slot(1, AW'({3'((loc + 1) % LOCS), 2'(lo ^ 1)}), w, '0, 1'b0, "");
          end
          if (i % 5 == 0) slot(0, '0, w, '0, 1'b0, "");
          slot(2, AW'({3'(loc), 2'((lo + i) % 4)}), w, '0, (i % 3) == 1,
               "R8 forward R2 order R5 mask");
          slot(2, AW'({3'((loc + 1) % LOCS), 2'(i % 4)}), w, '0, (i % 3) == 2,
               "R7 commit R3 drop R6 timing");
          i++;
        end
    slot(0, '0, w, '0, 1'b0, "");
    slot(0, '0, w, '0, 1'b0, "");
    summary();
  end
endmodule